// File: doc/BRIEF.md
# Latched Interrupt Status Register

This block collects the condition flags produced by a line transceiver's monitors and presents them to a host as a five-bit status word. The monitors are a line-level comparator, a driver fault detector, a regulator undervoltage detector, a supply undervoltage detector and a die-temperature monitor. The temperature monitor reports two levels: above the warning threshold, and below a lower recovery threshold. Every condition input first passes through a multi-flop synchronizer.

Four of the status bits are sticky interrupt flags. Each one latches on the rising edge of its synchronized source and is cleared by a read. The fifth bit is a live level. A single-cycle read strobe stands in for the serial host access. The block drives an active-low interrupt request and an active-high regulator undervoltage indicator. It also exposes the live fault, supply-undervoltage and overtemperature flags.

The regulator undervoltage source is the only one that can be masked. The temperature interrupt re-arms only after the die has cooled below the recovery threshold.

Top module: `irq_status_reg`

## Requirements
- R1: Status bit 4 is the inverse of the synchronized line level (1 when the line is low, 0 when the line is high). It is not latched and never affects the interrupt request. It follows the line input two clock edges after the input changes.
- R2: A read strobe captures the status word into the read-data output at the next clock edge. At that same edge, bits 3..0 are cleared. Bit 4 is not changed by a read.
- R3: A rising edge of the driver fault input sets status bit 3 three clock edges later. The fault flag output follows the fault input two edges after it changes.
- R4: A rising edge of the regulator undervoltage input sets status bit 2 whether or not its enable is set. Bit 2 requests an interrupt only while the enable input is 1.
- R5: The undervoltage output is high one edge after both the enable and the synchronized regulator undervoltage are high. It is not cleared by a read. It drops once the regulator input has been low for three edges.
- R6: A rising edge of the supply undervoltage input sets status bit 1, and this bit always requests an interrupt. The supply-UV flag output follows the input.
- R7: A rising edge of the temperature-warning input sets status bit 0 only when the block is armed. The block is armed out of reset and re-armed whenever the recovery input has been seen high. Setting bit 0 disarms it, so a warning that drops and returns without recovery does not set bit 0 again. The overtemperature flag output follows the warning input.
- R8: The interrupt request output is active low. It is low while any of bits 3, 1 or 0 is set, or while bit 2 is set with its enable at 1.
- R9: A source held active across a read does not set its bit again.
- R10: A rising-edge event in the same cycle as a read leaves its bit set after the read. The read data still shows the value from before the event.
- R11: After reset, bits 3..0 and the read data are 0, the interrupt request is high, and the undervoltage output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| line_high_i | input | 1 | Line comparator output, 1 = line high |
| drv_fault_i | input | 1 | Driver short or voltage fault condition |
| reg_uv_i | input | 1 | Regulator undervoltage condition |
| sup_uv_i | input | 1 | Supply undervoltage condition |
| temp_warn_i | input | 1 | Die temperature above warning threshold |
| temp_ok_i | input | 1 | Die temperature below recovery threshold |
| reg_uv_en_i | input | 1 | Enable for regulator undervoltage interrupt and indicator |
| rd_stb_i | input | 1 | Single-cycle status read strobe |
| status_o | output | 5 | Current status word |
| rd_data_o | output | 5 | Status word captured by the last read |
| irq_n_o | output | 1 | Active-low interrupt request |
| uv_o | output | 1 | Active-high regulator undervoltage indicator |
| drv_fault_flag_o | output | 1 | Live synchronized driver fault flag |
| sup_uv_flag_o | output | 1 | Live synchronized supply undervoltage flag |
| otemp_flag_o | output | 1 | Live synchronized overtemperature flag |

## Verification
The bench builds the block with the default two-stage synchronizer and derives every sampling delay from that stage count. This brings within reach one particular race: a source edge timed so that its detection cycle coincides with a read strobe, which exercises the capture-before-clear ordering. With the same stage count, the bench walks the temperature sequence warning, partial cooling, warning, full recovery, warning. It also toggles the regulator enable while that bit is pending, which separates the latched bit from both the masked request and the indicator.

// File: rtl/irqs_pkg.sv
// Package: shared widths and bit positions for the latched status register.
// Assumes: the bit positions below are decoded by the host, so they are fixed.
package irqs_pkg;
    localparam int STAT_W    = 5;
    localparam int NUM_LATCH = 4;
    localparam int IDX_OT    = 0;
    localparam int IDX_SUV   = 1;
    localparam int IDX_RUV   = 2;
    localparam int IDX_DRV   = 3;
    localparam int IDX_LINE  = 4;
    // synchronized input vector positions
    localparam int SY_LINE   = 0;
    localparam int SY_DRV    = 1;
    localparam int SY_RUV    = 2;
    localparam int SY_SUV    = 3;
    localparam int SY_WARN   = 4;
    localparam int SY_OK     = 5;
    localparam int SYNC_W    = 6;
    typedef logic [NUM_LATCH-1:0] latch_vec_t;
    typedef logic [STAT_W-1:0]    stat_vec_t;
endpackage

// File: rtl/flag_sync.sv
// Module: multi-stage synchronizer for a vector of condition flags.
// Assumes: each bit is an independent level; no bus coherency is needed.
module flag_sync #(
    parameter int WIDTH  = 6,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);
    logic [WIDTH-1:0] stg [STAGES];

    // shift the flags through the synchronizer chain
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < STAGES; k++) stg[k] <= '0;
        end else begin
            stg[0] <= d_i;
            for (int k = 1; k < STAGES; k++) stg[k] <= stg[k-1];
        end
    end

    assign q_o = stg[STAGES-1];
endmodule

// File: rtl/rise_detect.sv
// Module: per-bit rising-edge detector on synchronized flags.
// Assumes: inputs are already synchronous; output is a one-cycle pulse.
module rise_detect #(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] lvl_i,
    output logic [WIDTH-1:0] rise_o
);
    logic [WIDTH-1:0] prev_q;

    // remember the previous level of each flag
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= lvl_i;
    end

    assign rise_o = lvl_i & ~prev_q;

    // R9
    rise_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rise_o != '0) |=> ((rise_o & $past(rise_o)) == '0));
endmodule

// File: rtl/temp_rearm.sv
// Module: overtemperature event gate with hysteresis re-arm.
// Assumes: warn and recovery levels are synchronous and never both high.
module temp_rearm (
    input  logic clk,
    input  logic rst_n,
    input  logic warn_rise_i,
    input  logic ok_i,
    output logic set_o
);
    logic armed_q;

    // arm on recovery, disarm once an event has been passed on
    always_ff @(posedge clk) begin
        if (!rst_n)           armed_q <= 1'b1;
        else if (ok_i)        armed_q <= 1'b1;
        else if (set_o)       armed_q <= 1'b0;
    end

    assign set_o = warn_rise_i & armed_q;

    // R7
    rearm_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (set_o && !ok_i) |=> !set_o);
endmodule

// File: rtl/irq_status_reg.sv
// Module: latched interrupt status register for a line transceiver.
// Holds four read-to-clear interrupt bits and one live line-level bit,
// drives an active-low interrupt request and an undervoltage indicator.
// Assumes: condition inputs may be asynchronous; rd_stb_i is one cycle wide.
module irq_status_reg
    import irqs_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              line_high_i,
    input  logic              drv_fault_i,
    input  logic              reg_uv_i,
    input  logic              sup_uv_i,
    input  logic              temp_warn_i,
    input  logic              temp_ok_i,
    input  logic              reg_uv_en_i,
    input  logic              rd_stb_i,
    output logic [STAT_W-1:0] status_o,
    output logic [STAT_W-1:0] rd_data_o,
    output logic              irq_n_o,
    output logic              uv_o,
    output logic              drv_fault_flag_o,
    output logic              sup_uv_flag_o,
    output logic              otemp_flag_o
);
    logic [SYNC_W-1:0] raw_vec;
    logic [SYNC_W-1:0] syn_vec;
    latch_vec_t        lvl_vec;
    latch_vec_t        rise_vec;
    latch_vec_t        evt_vec;
    latch_vec_t        flag_q;
    stat_vec_t         rd_q;
    logic              ot_set;
    logic              uv_q;

    assign raw_vec[SY_LINE] = line_high_i;
    assign raw_vec[SY_DRV]  = drv_fault_i;
    assign raw_vec[SY_RUV]  = reg_uv_i;
    assign raw_vec[SY_SUV]  = sup_uv_i;
    assign raw_vec[SY_WARN] = temp_warn_i;
    assign raw_vec[SY_OK]   = temp_ok_i;

    flag_sync #(.WIDTH(SYNC_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .d_i(raw_vec), .q_o(syn_vec)
    );

    assign lvl_vec[IDX_DRV] = syn_vec[SY_DRV];
    assign lvl_vec[IDX_RUV] = syn_vec[SY_RUV];
    assign lvl_vec[IDX_SUV] = syn_vec[SY_SUV];
    assign lvl_vec[IDX_OT]  = syn_vec[SY_WARN];

    rise_detect #(.WIDTH(NUM_LATCH)) u_rise (
        .clk(clk), .rst_n(rst_n), .lvl_i(lvl_vec), .rise_o(rise_vec)
    );

    temp_rearm u_temp (
        .clk(clk), .rst_n(rst_n), .warn_rise_i(rise_vec[IDX_OT]),
        .ok_i(syn_vec[SY_OK]), .set_o(ot_set)
    );

    // events per latched bit; temperature goes through the re-arm gate
    always_comb begin
        evt_vec         = rise_vec;
        evt_vec[IDX_OT] = ot_set;
    end

    genvar gi;
    generate
        for (gi = 0; gi < NUM_LATCH; gi++) begin : g_flag
            // read clears, a same-cycle event wins over the clear
            always_ff @(posedge clk) begin
                if (!rst_n) flag_q[gi] <= 1'b0;
                else        flag_q[gi] <= (flag_q[gi] & ~rd_stb_i) | evt_vec[gi];
            end
        end
    endgenerate

    assign status_o = {~syn_vec[SY_LINE], flag_q};

    // capture the pre-clear status word on a read
    always_ff @(posedge clk) begin
        if (!rst_n)        rd_q <= '0;
        else if (rd_stb_i) rd_q <= status_o;
    end

    // undervoltage indicator follows the enabled live regulator condition
    always_ff @(posedge clk) begin
        if (!rst_n) uv_q <= 1'b0;
        else        uv_q <= reg_uv_en_i & syn_vec[SY_RUV];
    end

    assign rd_data_o        = rd_q;
    assign uv_o             = uv_q;
    assign irq_n_o          = ~(flag_q[IDX_DRV] | flag_q[IDX_SUV] | flag_q[IDX_OT]
                                | (flag_q[IDX_RUV] & reg_uv_en_i));
    assign drv_fault_flag_o = syn_vec[SY_DRV];
    assign sup_uv_flag_o    = syn_vec[SY_SUV];
    assign otemp_flag_o     = syn_vec[SY_WARN];

    // R2
    rd_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb_i && evt_vec == '0) |=> (status_o[NUM_LATCH-1:0] == '0));
    // R2
    rd_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_stb_i |=> (rd_data_o == $past(status_o)));
    // R10
    evt_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        evt_vec[IDX_DRV] |=> status_o[IDX_DRV]);
    // R6
    sup_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        status_o[IDX_SUV] |-> !irq_n_o);
    // R5
    uv_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_uv_en_i |=> !uv_o);
endmodule

// File: tb/sim_irq_status_reg.sv
`timescale 1ns/1ps
module sim_irq_status_reg;
    localparam int STG = 2;
    localparam int LAT = STG + 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic line_high_i = 1'b1, drv_fault_i = 1'b0, reg_uv_i = 1'b0, sup_uv_i = 1'b0;
    logic temp_warn_i = 1'b0, temp_ok_i = 1'b0, reg_uv_en_i = 1'b0, rd_stb_i = 1'b0;
    logic [4:0] status_o, rd_data_o;
    logic irq_n_o, uv_o, drv_fault_flag_o, sup_uv_flag_o, otemp_flag_o;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    typedef struct {
        int         sel;
        logic [4:0] exp;
        string      req;
    } item_t;
    item_t sb_q[$];

    always #2 clk = ~clk;

    irq_status_reg #(.SYNC_STAGES(STG)) u0 (
        .clk(clk), .rst_n(rst_n), .line_high_i(line_high_i), .drv_fault_i(drv_fault_i),
        .reg_uv_i(reg_uv_i), .sup_uv_i(sup_uv_i), .temp_warn_i(temp_warn_i),
        .temp_ok_i(temp_ok_i), .reg_uv_en_i(reg_uv_en_i), .rd_stb_i(rd_stb_i),
        .status_o(status_o), .rd_data_o(rd_data_o), .irq_n_o(irq_n_o), .uv_o(uv_o),
        .drv_fault_flag_o(drv_fault_flag_o), .sup_uv_flag_o(sup_uv_flag_o),
        .otemp_flag_o(otemp_flag_o)
    );

    // selector: 0 status, 1 read data, 2 irq_n, 3 uv, 4 {otemp,sup,drv} flags
    function automatic logic [4:0] observe(int sel);
        case (sel)
            0: return status_o;
            1: return rd_data_o;
            2: return {4'b0, irq_n_o};
            3: return {4'b0, uv_o};
            default: return {2'b0, otemp_flag_o, sup_uv_flag_o, drv_fault_flag_o};
        endcase
    endfunction

    task automatic expect_val(int sel, logic [4:0] exp, string req);
        item_t it;
        it.sel = sel;
        it.exp = exp;
        it.req = req;
        sb_q.push_back(it);
    endtask

    task automatic step(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_read();
        rd_stb_i = 1'b1;
        step(1);
        rd_stb_i = 1'b0;
    endtask

    // monitor: pop expected items and compare just after the falling edge
    initial begin
        forever begin
            @(negedge clk);
            #1;
            while (sb_q.size() > 0) begin
                item_t it;
                logic [4:0] act;
                it = sb_q.pop_front();
                act = observe(it.sel);
                checks++;
                if (act !== it.exp) begin
                    failures++;
                    $display("FAIL %s sel=%0d actual=%b expected=%b", it.req, it.sel, act, it.exp);
                end
            end
        end
    end

    initial begin
        #(4 * 200000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        step(5);
        rst_n = 1'b1;
        step(LAT);
        // R11 reset state
        expect_val(0, 5'b00000, "R11");
        expect_val(1, 5'b00000, "R11");
        expect_val(2, 5'b00001, "R11");
        expect_val(3, 5'b00000, "R11");

        // R1 live line bit
        line_high_i = 1'b0;
        step(STG);
        expect_val(0, 5'b10000, "R1");
        expect_val(2, 5'b00001, "R1");
        // R2 read leaves bit 4 alone
        do_read();
        expect_val(1, 5'b10000, "R2");
        expect_val(0, 5'b10000, "R2");
        line_high_i = 1'b1;
        step(STG);
        expect_val(0, 5'b00000, "R1");

        // R3 driver fault
        drv_fault_i = 1'b1;
        step(LAT);
        expect_val(0, 5'b01000, "R3");
        expect_val(4, 5'b00001, "R3");
        expect_val(2, 5'b00000, "R8");
        do_read();
        expect_val(1, 5'b01000, "R2");
        expect_val(0, 5'b00000, "R2");
        expect_val(2, 5'b00001, "R8");
        step(LAT);
        expect_val(0, 5'b00000, "R9");
        drv_fault_i = 1'b0;
        step(LAT);
        expect_val(4, 5'b00000, "R3");

        // R4 masked regulator undervoltage
        reg_uv_i = 1'b1;
        step(LAT);
        expect_val(0, 5'b00100, "R4");
        expect_val(2, 5'b00001, "R4");
        expect_val(3, 5'b00000, "R5");
        step(1);
        reg_uv_en_i = 1'b1;
        expect_val(2, 5'b00000, "R4");
        step(1);
        expect_val(3, 5'b00001, "R5");
        do_read();
        expect_val(1, 5'b00100, "R2");
        expect_val(2, 5'b00001, "R8");
        expect_val(3, 5'b00001, "R5");
        reg_uv_i = 1'b0;
        step(LAT);
        expect_val(3, 5'b00000, "R5");

        // R6 supply undervoltage
        sup_uv_i = 1'b1;
        step(LAT);
        expect_val(0, 5'b00010, "R6");
        expect_val(2, 5'b00000, "R6");
        expect_val(4, 5'b00010, "R6");
        do_read();
        expect_val(0, 5'b00000, "R6");
        sup_uv_i = 1'b0;
        step(LAT);

        // R7 temperature with hysteresis
        temp_warn_i = 1'b1;
        step(LAT);
        expect_val(0, 5'b00001, "R7");
        expect_val(4, 5'b00100, "R7");
        do_read();
        expect_val(0, 5'b00000, "R7");
        temp_warn_i = 1'b0;
        step(LAT);
        temp_warn_i = 1'b1;
        step(LAT);
        expect_val(0, 5'b00000, "R7");
        expect_val(2, 5'b00001, "R7");
        temp_warn_i = 1'b0;
        temp_ok_i = 1'b1;
        step(LAT);
        temp_ok_i = 1'b0;
        temp_warn_i = 1'b1;
        step(LAT);
        expect_val(0, 5'b00001, "R7");
        do_read();
        temp_warn_i = 1'b0;
        step(LAT);

        // R10 event in the same cycle as a read
        sup_uv_i = 1'b1;
        step(LAT);
        drv_fault_i = 1'b1;
        step(STG);
        do_read();
        expect_val(1, 5'b00010, "R10");
        expect_val(0, 5'b01000, "R10");
        expect_val(2, 5'b00000, "R10");
        sup_uv_i = 1'b0;
        drv_fault_i = 1'b0;
        do_read();
        expect_val(0, 5'b00000, "R2");

        step(3);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule